// File: doc/BRIEF.md
# Selectable Byte/Word DMA Memory Port

This block is the bus-master side of a serial-bus terminal core. It moves 16-bit words to and from a shared RAM. The core presents an access as an address, a direction and write data, and pulses a start input. The port then raises a bus request and waits for the active-low acknowledge. Once granted, it runs the transfer and pulses done. For a read, the assembled word is presented together with done.

A mode input picks the data path. In word mode one transfer carries the whole word, and the lowest address line is held at 1. In byte mode the word is split into two transfers, low byte first. The lowest address line carries the lane: 0 for the low byte and 1 for the high byte. The two byte lanes of the RAM data bus are wired together outside the port, so a byte being written is driven on both halves of the data bus.

Each transfer takes three clocks: address setup, strobe and hold. The pads are described as value/enable pairs. Address and data enables are low whenever acknowledge is high. A separate float input forces the address and control enables low, and the active-low chip select and write then rest on board pull-ups. Mode and direction are sampled at start and held for the whole access.

Top module: `dma_mem_port`

## Requirements
- R1: After reset, bus_req, done, mem_addr_oe and mem_data_oe are 0, and mem_cs_n_o and mem_we_n_o are 1.
- R2: A start pulse seen while idle raises bus_req on the next clock. bus_req stays high until the cycle after done. No address or data enable is raised before ack_n has been low at a clock edge.
- R3: With byte_mode = 0, an access makes exactly one transfer with mem_addr_o[0] = 1. That transfer carries all 16 bits, so word writes and reads round-trip unchanged.
- R4: With byte_mode = 1, an access makes two transfers. The first has mem_addr_o[0] = 0 and carries bits 7:0 of the word. The second has mem_addr_o[0] = 1 and carries bits 15:8. mem_addr_o[AW:1] holds the word address.
- R5: In byte-mode writes, mem_data_o[15:8] equals mem_data_o[7:0] whenever mem_data_oe is 1.
- R6: Each transfer drives the address for three cycles (setup, strobe, hold). mem_cs_n_o is low only in the strobe cycle. mem_we_n_o is low in that cycle for writes only. The address stays stable across the strobe.
- R7: done is high for exactly one cycle, in the final hold cycle. For a read, rdata holds the complete word in that cycle.
- R8: While ack_n is 1, mem_addr_oe and mem_data_oe are 0.
- R9: While addr_float is 1, mem_addr_oe is 0, so chip select and write float high and the RAM is not touched. mem_data_oe still follows the transfer.
- R10: A start pulse that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 0 = word transfers, 1 = two byte transfers |
| addr_float | input | 1 | 1 forces the address and control enables low |
| start | input | 1 | Begin an access (taken while idle) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Read word, valid with done |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| ack_n | input | 1 | Active-low bus grant |
| mem_addr_o | output | AW+1 | RAM address; bit 0 is the byte lane |
| mem_addr_oe | output | 1 | Enable for address, chip select and write pads |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_data_o | output | 16 | Data driven to RAM |
| mem_data_oe | output | 1 | Enable for data pads |
| mem_data_i | input | 16 | Data returned by RAM |

## Verification
Two functions can act in the same cycle. A new start request can arrive while an access is still running, and the float enable can be high while a write strobe is in progress. The bench pulses start in the middle of a running write, aimed at another address. It judges the outcome by the number of strobes and by the untouched RAM word at that address. It also runs a whole word write with addr_float held high. That test passes if the address enable never rises, the data enable still covers three cycles, and a later read returns the old RAM contents.

// File: rtl/dma_mem_port.sv
module dma_mem_port #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          addr_float,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          bus_req,
  input  logic          ack_n,
  output logic [AW:0]   mem_addr_o,
  output logic          mem_addr_oe,
  output logic          mem_cs_n_o,
  output logic          mem_we_n_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_data_oe,
  input  logic [DW-1:0] mem_data_i
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t        state;
  logic          lane, wr_q, mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] wbyte;
  logic          last, active, own;

  assign last   = !mode_q || lane;
  assign active = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign own    = active && !ack_n;
  assign wbyte  = lane ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];

  assign bus_req     = (state != S_IDLE);
  assign done        = (state == S_HOLD) && last;
  assign mem_addr_oe = own && !addr_float;
  assign mem_addr_o  = {addr_q, mode_q ? lane : 1'b1};
  assign mem_cs_n_o  = !(state == S_STROBE);
  assign mem_we_n_o  = !((state == S_STROBE) && wr_q);
  assign mem_data_oe = own && wr_q;
  assign mem_data_o  = mode_q ? {2{wbyte}} : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      lane    <= 1'b0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          lane    <= 1'b0;
          wr_q    <= wr;
          mode_q  <= byte_mode;
          addr_q  <= addr;
          wdata_q <= wdata;
        end
        S_REQ:    if (!ack_n) state <= S_SETUP;
        S_SETUP:  state <= S_STROBE;
        S_STROBE: begin
          state <= S_HOLD;
          if (!wr_q) begin
            if (!mode_q)   rdata <= mem_data_i;
            else if (lane) rdata[DW-1:BW] <= mem_data_i[DW-1:BW];
            else           rdata[BW-1:0]  <= mem_data_i[BW-1:0];
          end
        end
        S_HOLD: begin
          if (last) state <= S_IDLE;
          else begin
            lane  <= 1'b1;
            state <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_mem_port_chk.sv
module dma_mem_port_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_mode,
  input logic          addr_float,
  input logic          done,
  input logic          bus_req,
  input logic          ack_n,
  input logic [AW:0]   mem_addr_o,
  input logic          mem_addr_oe,
  input logic          mem_cs_n_o,
  input logic [DW-1:0] mem_data_o,
  input logic          mem_data_oe
);
  localparam int BW = DW / 2;

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !done) |=> bus_req);

  // R3
  word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n_o && !byte_mode) |-> mem_addr_o[0]);

  // R5
  byte_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_data_oe && byte_mode) |-> (mem_data_o[DW-1:BW] == mem_data_o[BW-1:0]));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n_o |=> mem_cs_n_o);

  // R6
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n_o |=> $stable(mem_addr_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  ack_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |-> !(mem_addr_oe || mem_data_oe));

  // R9
  addr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_float |-> !mem_addr_oe);
endmodule

bind dma_mem_port dma_mem_port_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .addr_float(addr_float),
  .done(done), .bus_req(bus_req), .ack_n(ack_n), .mem_addr_o(mem_addr_o),
  .mem_addr_oe(mem_addr_oe), .mem_cs_n_o(mem_cs_n_o), .mem_data_o(mem_data_o),
  .mem_data_oe(mem_data_oe)
);

// File: tb/dma_mem_port_tb_top.sv
`timescale 1ns/1ps
module dma_mem_port_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_mode = 1'b0, addr_float = 1'b0, start = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata, mem_data_o, mem_data_i;
  logic done, bus_req, ack_n, mem_addr_oe, mem_cs_n_o, mem_we_n_o, mem_data_oe;
  logic [AW:0] mem_addr_o;

  int tests = 0, fails = 0, grant_delay = 0, wait_cnt = 0;

  logic [15:0] wram [0:(1<<AW)-1];
  logic [7:0]  bram [0:(2<<AW)-1];

  always #2.5 clk = ~clk;

  dma_mem_port #(.AW(AW), .DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .addr_float(addr_float),
    .start(start), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .done(done), .bus_req(bus_req), .ack_n(ack_n), .mem_addr_o(mem_addr_o),
    .mem_addr_oe(mem_addr_oe), .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o),
    .mem_data_o(mem_data_o), .mem_data_oe(mem_data_oe), .mem_data_i(mem_data_i)
  );

  logic cs_pad, we_pad;
  assign cs_pad = mem_addr_oe ? mem_cs_n_o : 1'b1;
  assign we_pad = mem_addr_oe ? mem_we_n_o : 1'b1;
  assign mem_data_i = (!cs_pad && we_pad) ?
    (byte_mode ? {2{bram[mem_addr_o]}} : wram[mem_addr_o[AW:1]]) : 16'h0;

  always @(posedge clk) begin
    if (!cs_pad && !we_pad) begin
      if (byte_mode) bram[mem_addr_o] <= mem_data_o[7:0];
      else           wram[mem_addr_o[AW:1]] <= mem_data_o;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_n <= 1'b1; wait_cnt <= 0;
    end else if (!bus_req) begin
      ack_n <= 1'b1; wait_cnt <= 0;
    end else if (wait_cnt >= grant_delay) ack_n <= 1'b0;
    else wait_cnt <= wait_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] r_data;
  int n_strobe, n_oe, n_doe, n_we, dones;
  logic [7:0] a0_seq;
  bit lanes_ok, float_ok, req_ok, post_done, post_req;

  task automatic run_access(input bit w, input logic [AW-1:0] a,
                            input logic [15:0] d, input bit poke);
    bit fin = 0;
    n_strobe = 0; n_oe = 0; n_doe = 0; n_we = 0; dones = 0; a0_seq = '0;
    lanes_ok = 1; float_ok = 1;
    @(negedge clk);
    wr = w; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_ok = bus_req;
    for (int c = 0; c < 60 && !fin; c++) begin
      if (poke && c == 3) begin
        start = 1'b1; wr = 1'b1; addr = 8'd7; wdata = 16'hDEAD;
      end else start = 1'b0;
      if (ack_n && (mem_addr_oe || mem_data_oe)) float_ok = 0;
      if (mem_addr_oe) n_oe++;
      if (mem_data_oe) n_doe++;
      if (!mem_cs_n_o) begin
        n_strobe++;
        a0_seq = {a0_seq[6:0], mem_addr_o[0]};
        if (!mem_we_n_o) n_we++;
        if (byte_mode && mem_data_oe && mem_data_o[15:8] != mem_data_o[7:0]) lanes_ok = 0;
      end
      if (done) begin dones++; r_data = rdata; fin = 1; end
      @(negedge clk);
    end
    start = 1'b0;
    post_done = done;
    post_req = bus_req;
  endtask

  task automatic t_reset();
    chk(!bus_req && !done, "R1", "req/done at reset", {bus_req, done}, 0);
    chk(!mem_addr_oe && !mem_data_oe, "R1", "enables at reset", {mem_addr_oe, mem_data_oe}, 0);
    chk(mem_cs_n_o && mem_we_n_o, "R1", "strobes at reset", {mem_cs_n_o, mem_we_n_o}, 3);
  endtask

  task automatic t_word();
    byte_mode = 1'b0; grant_delay = 0;
    run_access(1'b1, 8'd5, 16'hBEEF, 1'b0);
    chk(req_ok, "R2", "bus_req after start", req_ok, 1);
    chk(n_strobe == 1, "R3", "word strobes", n_strobe, 1);
    chk(a0_seq[0] == 1'b1, "R3", "word A0", a0_seq[0], 1);
    chk(n_oe == 3, "R6", "word addr cycles", n_oe, 3);
    chk(n_we == 1, "R6", "write strobe count", n_we, 1);
    chk(dones == 1 && !post_done, "R7", "done pulse", {dones[3:0], post_done}, 5'h2);
    chk(!post_req, "R2", "bus_req drop after done", post_req, 0);
    chk(wram[5] == 16'hBEEF, "R3", "word stored", wram[5], 16'hBEEF);
    run_access(1'b0, 8'd5, 16'h0, 1'b0);
    chk(r_data == 16'hBEEF, "R3", "word readback", r_data, 16'hBEEF);
    chk(n_we == 0, "R6", "no write strobe on read", n_we, 0);
    run_access(1'b0, 8'd40, 16'h0, 1'b0);
    chk(r_data == wram[40], "R7", "word preload read", r_data, wram[40]);
  endtask

  task automatic t_byte();
    logic [15:0] exp;
    byte_mode = 1'b1; grant_delay = 0;
    run_access(1'b1, 8'd9, 16'h1234, 1'b0);
    chk(n_strobe == 2, "R4", "byte strobes", n_strobe, 2);
    chk(a0_seq[1:0] == 2'b01, "R4", "lane order", a0_seq[1:0], 2'b01);
    chk(lanes_ok, "R5", "lanes duplicated", lanes_ok, 1);
    chk(n_oe == 6, "R6", "byte addr cycles", n_oe, 6);
    chk(bram[18] == 8'h34 && bram[19] == 8'h12, "R4", "bytes stored",
        {bram[19], bram[18]}, 16'h1234);
    run_access(1'b0, 8'd9, 16'h0, 1'b0);
    chk(r_data == 16'h1234, "R7", "byte readback", r_data, 16'h1234);
    exp = {bram[81], bram[80]};
    run_access(1'b0, 8'd40, 16'h0, 1'b0);
    chk(r_data == exp, "R4", "byte preload assemble", r_data, exp);
    chk(dones == 1 && !post_done, "R7", "byte done pulse", {dones[3:0], post_done}, 5'h2);
  endtask

  task automatic t_grant_wait();
    byte_mode = 1'b0; grant_delay = 6;
    run_access(1'b1, 8'd12, 16'hC0DE, 1'b0);
    chk(float_ok, "R8", "no drive before grant", float_ok, 1);
    chk(wram[12] == 16'hC0DE, "R2", "write after late grant", wram[12], 16'hC0DE);
    byte_mode = 1'b1;
    run_access(1'b0, 8'd9, 16'h0, 1'b0);
    chk(float_ok && r_data == 16'h1234, "R8", "byte read late grant", r_data, 16'h1234);
    grant_delay = 0;
  endtask

  task automatic t_float();
    logic [15:0] old;
    byte_mode = 1'b0; old = wram[3];
    addr_float = 1'b1;
    run_access(1'b1, 8'd3, 16'h5555, 1'b0);
    addr_float = 1'b0;
    chk(n_oe == 0, "R9", "addr enable stays low", n_oe, 0);
    chk(n_doe == 3, "R9", "data enable still active", n_doe, 3);
    run_access(1'b0, 8'd3, 16'h0, 1'b0);
    chk(r_data == old, "R9", "RAM untouched", r_data, old);
  endtask

  task automatic t_busy();
    logic [15:0] old7;
    byte_mode = 1'b0; old7 = wram[7];
    run_access(1'b1, 8'd20, 16'hA1B2, 1'b1);
    chk(n_strobe == 1 && dones == 1, "R10", "single access", n_strobe, 1);
    chk(wram[7] == old7, "R10", "late start ignored", wram[7], old7);
    chk(wram[20] == 16'hA1B2, "R10", "running write intact", wram[20], 16'hA1B2);
    chk(!bus_req, "R10", "idle after ignored start", bus_req, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) wram[i] = 16'(i * 37) ^ 16'h5A00;
    for (int i = 0; i < (2<<AW); i++) bram[i] = 8'(i * 13 + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_word();
    t_byte();
    t_grant_wait();
    t_float();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule